// File: doc/BRIEF.md
# Serial Controller FIFO and Event Block

This block sits between a host register port and the shift engine of a serial controller. It keeps one FIFO for words going out and one for words coming in. The host writes outgoing words and reads incoming words through a small register-style port. The shift engine pops outgoing words and pushes received words through a push/pop port.

Six event sources feed sticky flags: receive overrun, transmit underrun, receive level, transmit level, end of transfer, and a command received in slave role. Software clears a flag by writing 1 to its bit. A per-source enable mask combines the flags into a single interrupt line. The two level conditions also drive a transmit DMA request and a receive DMA request, and each request has its own enable bit. The FIFO depth is set at build time as 2 shifted left by a size field. The block reports that depth together with the live word count of each FIFO.

Register map (3-bit address): 0 data (a write pushes onto the outgoing FIFO, a read pops the incoming FIFO), 1 control, 2 interrupt enable, 3 flags, 4 fill counts, 5 configuration.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: While reset is held, the flags, both fill counts, the interrupt enables, both DMA enables, irq, tx_dma_req and rx_dma_req all read 0. The transmit level resets to 0 and the receive level resets to the depth.
- R2: Words leave each FIFO in the order they entered. Register 4 reports the outgoing count in bits [15:0] and the incoming count in bits [31:16]. Reading register 0 returns the oldest incoming word, or 0 when that FIFO is empty. tx_data shows the oldest outgoing word, or 0 when that FIFO is empty.
- R3: An rx_push that arrives while the incoming FIFO holds depth words drops the word and sets flag bit 0 at that clock edge.
- R4: A tx_pop that arrives while the outgoing FIFO is empty sets flag bit 1, and the count stays 0.
- R5: Flag bit 2 is set on the cycle after the incoming count is at or above the receive level. Flag bit 3 is set on the cycle after the outgoing count is at or below the transmit level.
- R6: A one-cycle xfer_end pulse sets flag bit 4. A one-cycle slv_cmd pulse sets flag bit 5.
- R7: Writing register 3 clears each flag whose data bit is 1 and leaves the other flags unchanged. If a flag is set and cleared in the same cycle, the set takes priority.
- R8: irq is high exactly when some flag bit is set and the matching bit [5:0] of register 2 is 1. Each enable bit is written on its own.
- R9: tx_dma_req is the product of control bit 2 and the transmit level condition. rx_dma_req is the product of control bit 3 and the receive level condition. Both requests follow the current counts with no flag delay.
- R10: The transmit level is held in control bits [8 +: CW] and the receive level in control bits [16 +: CW]. A level written above the depth is stored as the depth.
- R11: Register 5 returns the size field in bits [3:0] and the depth in words, 2 << size, in bits [31:16].
- R12: Writing control bit 0 empties the outgoing FIFO and writing control bit 1 empties the incoming FIFO. Each leaves the other FIFO untouched, and both bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops on address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr |
| tx_pop | input | 1 | Engine takes the oldest outgoing word |
| tx_data | output | DW | Oldest outgoing word |
| rx_push | input | 1 | Engine delivers a received word |
| rx_data | input | DW | Received word |
| xfer_end | input | 1 | End-of-transfer pulse |
| slv_cmd | input | 1 | Slave command received pulse |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with DW = 32 and size field 2, which gives a depth of 8. With that depth, nine pushes are enough to reach an overrun, and the 4-bit level fields can hold values up to 15, so a level above the depth can be written to check the clamp. A long random run mixes host and engine traffic with random levels, enables and clears. Every read, every popped word, irq and both DMA requests are compared against a queue model kept in the bench.

// File: rtl/sfic_pkg.sv
package sfic_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_EV   = 6;
  localparam int EV_RXOVF = 0;
  localparam int EV_TXUNF = 1;
  localparam int EV_RXLVL = 2;
  localparam int EV_TXLVL = 3;
  localparam int EV_END   = 4;
  localparam int EV_CMD   = 5;

  localparam logic [2:0] ADR_DATA = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_IEN  = 3'd2;
  localparam logic [2:0] ADR_FLAG = 3'd3;
  localparam logic [2:0] ADR_STAT = 3'd4;
  localparam logic [2:0] ADR_CFG  = 3'd5;
endpackage

// File: rtl/sfic_fifo.sv
module sfic_fifo #(
  parameter int DW = 32,
  parameter int AW = 3,
  localparam int DEPTH = 1 << AW,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign do_push = push && (cnt_q != FULL_C) && !flush;
  assign do_pop  = pop && (cnt_q != '0) && !flush;
  assign rdata   = (cnt_q == '0) ? '0 : mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_push) wptr_d = wptr_q + 1'b1;
      if (do_pop)  rptr_d = rptr_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/sfic_events.sv
module sfic_events #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_set,
  input  logic [N-1:0] ev_clr,
  input  logic [N-1:0] ev_en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_q, flags_d;

  // a new event outranks a clear in the same cycle
  assign flags_d = (flags_q & ~ev_clr) | ev_set;
  assign flags   = flags_q;
  assign irq     = |(flags_q & ev_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import sfic_pkg::*;
#(
  parameter int DW = 32,
  parameter int SIZE_SEL = 2,
  localparam int DEPTH = 2 << SIZE_SEL,
  localparam int AW = SIZE_SEL + 1,
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tx_pop,
  output logic [DW-1:0]    tx_data,
  input  logic             rx_push,
  input  logic [DW-1:0]    rx_data,
  input  logic             xfer_end,
  input  logic             slv_cmd,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_head;
  logic [CW-1:0] tx_lvl_q, tx_lvl_d, rx_lvl_q, rx_lvl_d;
  logic          tx_den_q, tx_den_d, rx_den_q, rx_den_d;
  logic [NUM_EV-1:0] ien_q, ien_d, ev_set, ev_clr, flags_w;
  logic          wr_data, wr_ctrl, wr_ien, wr_flag, rd_data;
  logic          tx_flush, rx_flush, tx_lvl_hit, rx_lvl_hit, rx_full, tx_empty;

  function automatic logic [CW-1:0] clamp_lvl(input logic [CW-1:0] v);
    return (v > DEPTH_C) ? DEPTH_C : v;
  endfunction

  assign wr_data  = reg_wr && (reg_addr == ADR_DATA);
  assign wr_ctrl  = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_ien   = reg_wr && (reg_addr == ADR_IEN);
  assign wr_flag  = reg_wr && (reg_addr == ADR_FLAG);
  assign rd_data  = reg_rd && (reg_addr == ADR_DATA);
  assign tx_flush = wr_ctrl && reg_wdata[0];
  assign rx_flush = wr_ctrl && reg_wdata[1];

  sfic_fifo #(.DW(DW), .AW(AW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(wr_data), .wdata(reg_wdata[DW-1:0]),
    .pop(tx_pop), .rdata(tx_data), .count(tx_cnt)
  );

  sfic_fifo #(.DW(DW), .AW(AW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .wdata(rx_data),
    .pop(rd_data), .rdata(rx_head), .count(rx_cnt)
  );

  assign rx_full    = (rx_cnt == DEPTH_C);
  assign tx_empty   = (tx_cnt == '0);
  assign rx_lvl_hit = (rx_cnt >= rx_lvl_q);
  assign tx_lvl_hit = (tx_cnt <= tx_lvl_q);
  assign tx_dma_req = tx_den_q && tx_lvl_hit;
  assign rx_dma_req = rx_den_q && rx_lvl_hit;

  always_comb begin
    ev_set = '0;
    ev_set[EV_RXOVF] = rx_push && rx_full;
    ev_set[EV_TXUNF] = tx_pop && tx_empty;
    ev_set[EV_RXLVL] = rx_lvl_hit;
    ev_set[EV_TXLVL] = tx_lvl_hit;
    ev_set[EV_END]   = xfer_end;
    ev_set[EV_CMD]   = slv_cmd;
  end

  assign ev_clr = wr_flag ? reg_wdata[NUM_EV-1:0] : '0;

  sfic_events #(.N(NUM_EV)) u_ev (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
    .ev_en(ien_q), .flags(flags_w), .irq(irq)
  );

  // configuration next state
  always_comb begin
    tx_lvl_d = tx_lvl_q;
    rx_lvl_d = rx_lvl_q;
    tx_den_d = tx_den_q;
    rx_den_d = rx_den_q;
    ien_d    = ien_q;
    if (wr_ctrl) begin
      tx_den_d = reg_wdata[2];
      rx_den_d = reg_wdata[3];
      tx_lvl_d = clamp_lvl(reg_wdata[8 +: CW]);
      rx_lvl_d = clamp_lvl(reg_wdata[16 +: CW]);
    end
    if (wr_ien) ien_d = reg_wdata[NUM_EV-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lvl_q <= '0;
      rx_lvl_q <= DEPTH_C;
      tx_den_q <= 1'b0;
      rx_den_q <= 1'b0;
      ien_q    <= '0;
    end else begin
      tx_lvl_q <= tx_lvl_d;
      rx_lvl_q <= rx_lvl_d;
      tx_den_q <= tx_den_d;
      rx_den_q <= rx_den_d;
      ien_q    <= ien_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_DATA: reg_rdata[DW-1:0] = rx_head;
      ADR_CTRL: begin
        reg_rdata[2]       = tx_den_q;
        reg_rdata[3]       = rx_den_q;
        reg_rdata[8 +: CW] = tx_lvl_q;
        reg_rdata[16 +: CW] = rx_lvl_q;
      end
      ADR_IEN:  reg_rdata[NUM_EV-1:0] = ien_q;
      ADR_FLAG: reg_rdata[NUM_EV-1:0] = flags_w;
      ADR_STAT: begin
        reg_rdata[0 +: CW]  = tx_cnt;
        reg_rdata[16 +: CW] = rx_cnt;
      end
      ADR_CFG: begin
        reg_rdata[3:0]   = 4'(SIZE_SEL);
        reg_rdata[31:16] = 16'(DEPTH);
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sfic_checker.sv
module sfic_checker
  import sfic_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              tx_pop,
  input logic              rx_push,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic [CW-1:0]     tx_lvl_q,
  input logic [NUM_EV-1:0] flags_w,
  input logic [NUM_EV-1:0] ien_q,
  input logic              irq,
  input logic              tx_den_q,
  input logic              tx_dma_req
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(DEPTH)) |=> flags_w[EV_RXOVF]);

  assert_overrun_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(DEPTH)) |=> (rx_cnt == CW'(DEPTH)) || (rx_cnt == CW'(DEPTH - 1)) || (rx_cnt == '0));

  assert_underrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_cnt == '0) |=> flags_w[EV_TXUNF]);

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADR_FLAG) |=> (($past(flags_w) & ~flags_w) == '0));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags_w & ien_q) != '0));

  assert_dma_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_req |-> tx_den_q);

  assert_level_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl_q <= CW'(DEPTH));

  assert_tx_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_CTRL && reg_wdata[0]) |=> (tx_cnt == '0));
endmodule

bind spi_fifo_irq_ctrl sfic_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_pop(tx_pop), .rx_push(rx_push),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_lvl_q(tx_lvl_q),
  .flags_w(flags_w), .ien_q(ien_q), .irq(irq),
  .tx_den_q(tx_den_q), .tx_dma_req(tx_dma_req)
);

// File: tb/spi_fifo_irq_ctrl_test.sv
module spi_fifo_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE_SEL = 2;
  localparam int DEPTH = 2 << SIZE_SEL;

  logic        clk, rst_n, reg_wr, reg_rd, tx_pop, rx_push, xfer_end, slv_cmd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, tx_data, rx_data;
  logic        irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  logic [5:0]  mflags, mien;
  int          mtxlvl, mrxlvl;
  bit          mtxden, mrxden;

  spi_fifo_irq_ctrl #(.DW(32), .SIZE_SEL(SIZE_SEL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data),
    .xfer_end(xfer_end), .slv_cmd(slv_cmd), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      3'd0: v = (rxq.size() > 0) ? rxq[0] : 32'h0;
      3'd1: v = (32'(mrxlvl) << 16) | (32'(mtxlvl) << 8) | (32'(mrxden) << 3) | (32'(mtxden) << 2);
      3'd2: v = {26'h0, mien};
      3'd3: v = {26'h0, mflags};
      3'd4: v = (32'(rxq.size()) << 16) | 32'(txq.size());
      3'd5: v = (32'(DEPTH) << 16) | 32'(SIZE_SEL);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic int clampv(input int v);
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  // hop: 0 idle, 1 register write, 2 register read; caller sits at a falling edge
  task automatic step(input string tag, input int hop, input logic [2:0] adr,
                      input logic [31:0] wd, input bit pop, input bit push,
                      input logic [31:0] pd, input bit endp, input bit cmdp);
    logic [5:0] set, clr;
    bit tx_take, tx_put, rx_take, rx_put;
    reg_wr = (hop == 1); reg_rd = (hop == 2); reg_addr = adr; reg_wdata = wd;
    tx_pop = pop; rx_push = push; rx_data = pd; xfer_end = endp; slv_cmd = cmdp;
    #1;
    chk("R8 irq", {31'h0, irq}, {31'h0, |(mflags & mien)});
    chk("R9 tx_dma_req", {31'h0, tx_dma_req}, {31'h0, mtxden && (txq.size() <= mtxlvl)});
    chk("R9 rx_dma_req", {31'h0, rx_dma_req}, {31'h0, mrxden && (rxq.size() >= mrxlvl)});
    if (pop) chk((txq.size() > 0) ? "R2 tx_data" : "R4 tx_data", tx_data,
                 (txq.size() > 0) ? txq[0] : 32'h0);
    if (hop == 2) chk(tag, reg_rdata, exp_rd(adr));
    set = '0;
    set[0] = push && (rxq.size() == DEPTH);
    set[1] = pop && (txq.size() == 0);
    set[2] = (rxq.size() >= mrxlvl);
    set[3] = (txq.size() <= mtxlvl);
    set[4] = endp;
    set[5] = cmdp;
    clr = (hop == 1 && adr == 3'd3) ? wd[5:0] : 6'h0;
    tx_take = pop && (txq.size() > 0);
    tx_put  = (hop == 1) && (adr == 3'd0) && (txq.size() < DEPTH);
    rx_take = (hop == 2) && (adr == 3'd0) && (rxq.size() > 0);
    rx_put  = push && (rxq.size() < DEPTH);
    @(posedge clk);
    if (tx_take) void'(txq.pop_front());
    if (tx_put)  txq.push_back(wd);
    if (rx_take) void'(rxq.pop_front());
    if (rx_put)  rxq.push_back(pd);
    if (hop == 1 && adr == 3'd1) begin
      if (wd[0]) txq.delete();
      if (wd[1]) rxq.delete();
      mtxden = wd[2]; mrxden = wd[3];
      mtxlvl = clampv(int'(wd[11:8])); mrxlvl = clampv(int'(wd[19:16]));
    end
    if (hop == 1 && adr == 3'd2) mien = wd[5:0];
    mflags = (mflags & ~clr) | set;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; tx_pop = 0; rx_push = 0; xfer_end = 0; slv_cmd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("idle", 0, 3'd0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
    step(tag, 1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, 2, a, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    tx_pop = 0; rx_push = 0; rx_data = 0; xfer_end = 0; slv_cmd = 0;
    mflags = 0; mien = 0; mtxlvl = 0; mrxlvl = DEPTH; mtxden = 0; mrxden = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    reg_addr = 3'd3; #1; chk("R1 flags in reset", reg_rdata, 32'h0);
    reg_addr = 3'd4; #1; chk("R1 counts in reset", reg_rdata, 32'h0);
    reg_addr = 3'd1; #1; chk("R1 control in reset", reg_rdata, 32'(DEPTH) << 16);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    chk("R1 dma in reset", {30'h0, tx_dma_req, rx_dma_req}, 32'h0);
    rst_n = 1;
    idle(2);
    // R11 depth report
    rd("R11 config", 3'd5);
    chk("R11 literal", reg_rdata, 32'h0008_0002);
    // R10 clamp
    wr("R10", 3'd1, 32'h000F_0F00);
    rd("R10 clamp readback", 3'd1);
    wr("R10", 3'd1, 32'h0008_0000);
    // R3 overrun, R2 order
    for (int i = 0; i < DEPTH + 1; i++) step("R3", 0, 3'd0, 0, 0, 1, 32'hA000 + i, 0, 0);
    rd("R3 flags after overrun", 3'd3);
    rd("R2 counts full", 3'd4);
    for (int i = 0; i < DEPTH; i++) rd("R2 rx order", 3'd0);
    rd("R2 empty read", 3'd0);
    // R4 underrun
    step("R4", 0, 3'd0, 0, 1, 0, 0, 0, 0);
    rd("R4 flags after underrun", 3'd3);
    // R7 write 0 keeps, write 1 clears
    wr("R7", 3'd3, 32'h0);
    rd("R7 zero write keeps", 3'd3);
    wr("R7", 3'd3, 32'h3);
    rd("R7 one clears", 3'd3);
    // R6 pulses, R8 single enable
    wr("R8", 3'd2, 32'h10);
    step("R6", 0, 3'd0, 0, 0, 0, 0, 1, 0);
    step("R6", 0, 3'd0, 0, 0, 0, 0, 0, 1);
    rd("R6 flags after pulses", 3'd3);
    rd("R8 enable readback", 3'd2);
    wr("R8", 3'd3, 32'h10);
    // R9 one DMA enable only
    wr("R9", 3'd1, 32'h0000_0204);
    idle(1);
    chk("R9 rx request held off", {31'h0, rx_dma_req}, 32'h0);
    // R12 flush independence, R5 levels
    for (int i = 0; i < 3; i++) wr("R12", 3'd0, 32'hB000 + i);
    for (int i = 0; i < 3; i++) step("R12", 0, 3'd0, 0, 0, 1, 32'hC000 + i, 0, 0);
    wr("R5", 3'd1, 32'h0002_0000);
    wr("R5", 3'd3, 32'h3F);
    idle(1);
    rd("R5 rx level flag", 3'd3);
    wr("R12", 3'd1, 32'h0002_0001);
    rd("R12 tx flushed rx kept", 3'd4);
    rd("R12 flush bits read 0", 3'd1);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r, h;
      bit p, q, e, c;
      r = $urandom_range(0, 99);
      p = ($urandom_range(0, 99) < 35);
      q = ($urandom_range(0, 99) < 40);
      e = ($urandom_range(0, 99) < 3);
      c = ($urandom_range(0, 99) < 3);
      if (r < 30) step("R2 random write", 1, 3'd0, $urandom, p, q, $urandom, e, c);
      else if (r < 60) step("R2 random read", 2, 3'd0, 0, p, q, $urandom, e, c);
      else if (r < 70) begin
        h = $urandom_range(3, 5);
        step("R2 random status", 2, 3'(h), 0, p, q, $urandom, e, c);
      end else if (r < 74) step("R7 random clear", 1, 3'd3, $urandom, p, q, $urandom, e, c);
      else if (r < 77) step("R8 random enable", 1, 3'd2, $urandom, p, q, $urandom, e, c);
      else if (r < 80) begin
        logic [31:0] cw;
        cw = $urandom & 32'h000F_0F0C;
        if ($urandom_range(0, 9) == 0) cw[0] = 1'b1;
        if ($urandom_range(0, 9) == 0) cw[1] = 1'b1;
        step("R10 random control", 1, 3'd1, cw, p, q, $urandom, e, c);
      end else step("R5 random idle", 0, 3'd0, 0, p, q, $urandom, e, c);
    end
    rd("R5 final flags", 3'd3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule